// File: doc/BRIEF.md
# Pipelined Keccak-p[1600,24] permutation engine

This block applies the full 24-round Keccak permutation to a 1600-bit state. It does not know about hash modes. A surrounding sponge controller does the padding, picks the rate, XORs message blocks into the state and squeezes output. That controller hands a state to this engine and gets the permuted state back. The engine serves every SHA-3 hash and extendable-output mode, with single-block or multi-block messages.

The datapath holds two rounds in a row, so one trip around the loop advances a state by two rounds. Each round is split by a register that sits after theta, rho and pi and before chi and iota. A second register closes each round. The loop therefore has four register stages and can hold up to four independent states at once, one per stage. Each state carries its own tag and pass counter. The iota round constants are kept as 7-bit codes and widened to 64-bit lane constants on the fly.

A caller offers a state with a tag on the start port. The state is taken when the entry stage is free. 48 cycles later the result appears for one cycle, with the valid flag set and the same tag.

Top module: `kp1600_pipe`

## Requirements
- R1: After reset is released (plus the two-cycle synchroniser delay), `in_ready` is 1 and `out_valid` is 0, and they stay so while nothing is in flight.
- R2: The result of each state equals Keccak-p[1600,24] of the state given. Each round applies theta, rho, pi, chi and iota in that order. Lane (x,y) is held in bits [64*(x+5y)+63 : 64*(x+5y)]. The all-zero input gives lane (0,0) = 0xF1258F7940E1DDE7.
- R3: A state accepted in cycle c (`in_start` and `in_ready` both 1) produces `out_valid` in cycle c+48 and in no other cycle.
- R4: `out_tag` equals the `in_tag` given with the state when it was accepted.
- R5: Up to four states can be accepted in four consecutive cycles. Their results come out in the same order in four consecutive cycles, and never more than four states are in flight.
- R6: While a state that is not finished occupies the loop's last stage, `in_ready` is 0. A start offered in such a cycle is ignored and never yields a result.
- R7: In the cycle a result leaves, `in_ready` is 1, and a start offered in that cycle is accepted.
- R8: Iota uses 7 stored bits per round, placed at lane bit positions 0, 1, 3, 7, 15, 31 and 63. All other constant bits are 0.
- R9: States that are interleaved in the loop do not affect one another. Each result depends only on its own input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_start | input | 1 | Offer a state for permutation |
| in_tag | input | TAG_W | Context tag for the offered state |
| in_state | input | 1600 | State to permute |
| in_ready | output | 1 | Entry stage free; a start is taken in this cycle |
| out_valid | output | 1 | Permuted state present for one cycle |
| out_tag | output | TAG_W | Tag of the finished state |
| out_state | output | 1600 | Permuted state |

## Verification
The engine can finish one state and accept a new one in the same cycle. Both events use the entry stage at that edge: a finished state leaves from the last stage, and this frees the entry stage for the new one. The bench fills all four stages in consecutive cycles and then holds a further start pending. It checks that this start is refused through the whole fill, and that it is taken exactly in the cycle the first result appears. The late state's result is then compared with an independent permutation model 48 cycles later. Requests offered while the loop is saturated are shown never to produce a result.

// File: rtl/kp_pkg.sv
package kp_pkg;
  localparam int LANE_W  = 64;
  localparam int NLANES  = 25;
  localparam int STATE_W = LANE_W * NLANES;

  typedef logic [LANE_W-1:0]  lane_t;
  typedef logic [STATE_W-1:0] kstate_t;

  // Rotation offset for lane (x,y), derived by walking the rho trajectory.
  function automatic int rho_off(int x, int y);
    int cx;
    int cy;
    int nx;
    cx = 1;
    cy = 0;
    if (x == 0 && y == 0) return 0;
    for (int t = 0; t < 24; t++) begin
      if (cx == x && cy == y) return ((t + 1) * (t + 2) / 2) % 64;
      nx = cy;
      cy = (2 * cx + 3 * cy) % 5;
      cx = nx;
    end
    return 0;
  endfunction

  function automatic lane_t rotl(lane_t v, int n);
    if (n == 0) return v;
    return (v << n) | (v >> (LANE_W - n));
  endfunction

  // Compressed iota constant: bit j is placed at lane bit 2^j - 1.
  function automatic logic [6:0] rc_code(int r);
    case (r)
      0:  return 7'h01;  1:  return 7'h1A;  2:  return 7'h5E;  3:  return 7'h70;
      4:  return 7'h1F;  5:  return 7'h21;  6:  return 7'h79;  7:  return 7'h55;
      8:  return 7'h0E;  9:  return 7'h0C;  10: return 7'h35;  11: return 7'h26;
      12: return 7'h3F;  13: return 7'h4F;  14: return 7'h5D;  15: return 7'h53;
      16: return 7'h52;  17: return 7'h48;  18: return 7'h16;  19: return 7'h66;
      20: return 7'h79;  21: return 7'h58;  22: return 7'h21;  23: return 7'h74;
      default: return 7'h00;
    endcase
  endfunction

  function automatic lane_t rc_widen(logic [6:0] code);
    lane_t l;
    l = '0;
    for (int j = 0; j < 7; j++) l[(1 << j) - 1] = code[j];
    return l;
  endfunction
endpackage

// File: rtl/kp_rc_rom.sv
module kp_rc_rom #(
  parameter int NUM_ROUNDS = 24,
  parameter int IDX_W      = $clog2(NUM_ROUNDS)
) (
  input  logic [IDX_W-1:0] idx,
  output kp_pkg::lane_t    rc
);
  import kp_pkg::*;

  logic [6:0] code;

  always_comb begin
    if (int'(idx) < NUM_ROUNDS) code = rc_code(int'(idx));
    else                        code = 7'h00;
  end

  assign rc = rc_widen(code);
endmodule

// File: rtl/kp_theta_rho_pi.sv
module kp_theta_rho_pi (
  input  kp_pkg::kstate_t a,
  output kp_pkg::kstate_t b
);
  import kp_pkg::*;

  lane_t col [5];
  lane_t dmix [5];
  lane_t th [NLANES];

  for (genvar x = 0; x < 5; x++) begin : g_col
    assign col[x] = a[LANE_W*x +: LANE_W] ^ a[LANE_W*(x+5) +: LANE_W] ^
                    a[LANE_W*(x+10) +: LANE_W] ^ a[LANE_W*(x+15) +: LANE_W] ^
                    a[LANE_W*(x+20) +: LANE_W];
  end

  for (genvar x = 0; x < 5; x++) begin : g_dmix
    assign dmix[x] = col[(x+4)%5] ^ rotl(col[(x+1)%5], 1);
  end

  for (genvar y = 0; y < 5; y++) begin : g_y
    for (genvar x = 0; x < 5; x++) begin : g_x
      localparam int ROT  = rho_off(x, y);
      localparam int DEST = y + 5 * ((2 * x + 3 * y) % 5);
      assign th[x+5*y] = a[LANE_W*(x+5*y) +: LANE_W] ^ dmix[x];
      assign b[LANE_W*DEST +: LANE_W] = rotl(th[x+5*y], ROT);
    end
  end
endmodule

// File: rtl/kp_chi_iota.sv
module kp_chi_iota (
  input  kp_pkg::kstate_t a,
  input  kp_pkg::lane_t   rc,
  output kp_pkg::kstate_t b
);
  import kp_pkg::*;

  for (genvar y = 0; y < 5; y++) begin : g_y
    for (genvar x = 0; x < 5; x++) begin : g_x
      lane_t mixed;
      assign mixed = a[LANE_W*(x+5*y) +: LANE_W] ^
                     (~a[LANE_W*((x+1)%5+5*y) +: LANE_W] &
                       a[LANE_W*((x+2)%5+5*y) +: LANE_W]);
      if (x == 0 && y == 0) begin : g_iota
        assign b[LANE_W*(x+5*y) +: LANE_W] = mixed ^ rc;
      end else begin : g_plain
        assign b[LANE_W*(x+5*y) +: LANE_W] = mixed;
      end
    end
  end
endmodule

// File: rtl/kp1600_pipe.sv
module kp1600_pipe #(
  parameter int TAG_W      = 4,
  parameter int NUM_ROUNDS = 24,
  parameter int UNROLL     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_start,
  input  logic [TAG_W-1:0]     in_tag,
  input  logic [1599:0]        in_state,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic [TAG_W-1:0]     out_tag,
  output logic [1599:0]        out_state
);
  import kp_pkg::*;

  localparam int STAGES  = 2 * UNROLL;
  localparam int PASSES  = NUM_ROUNDS / UNROLL;
  localparam int LAST    = STAGES - 1;
  localparam int PASS_W  = (PASSES > 1) ? $clog2(PASSES) : 1;
  localparam int ROUND_W = (NUM_ROUNDS > 1) ? $clog2(NUM_ROUNDS) : 1;

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  // per-stage slot state
  logic [STAGES-1:0] vld_q, vld_d;
  logic [TAG_W-1:0]  tag_q  [STAGES];
  logic [TAG_W-1:0]  tag_d  [STAGES];
  logic [PASS_W-1:0] pass_q [STAGES];
  logic [PASS_W-1:0] pass_d [STAGES];
  kstate_t           st_q   [STAGES];
  kstate_t           st_d   [STAGES];

  logic    tail_final, recirc, accept;
  kstate_t head_state;

  assign tail_final = (pass_q[LAST] == PASS_W'(PASSES - 1));
  assign recirc     = vld_q[LAST] && !tail_final;
  assign in_ready   = !recirc;
  assign accept     = in_start && in_ready;
  assign head_state = recirc ? st_q[LAST] : in_state;

  // next-state for slot bookkeeping
  always_comb begin
    vld_d[0]  = recirc || accept;
    tag_d[0]  = recirc ? tag_q[LAST] : in_tag;
    pass_d[0] = recirc ? PASS_W'(pass_q[LAST] + 1'b1) : '0;
    for (int k = 1; k < STAGES; k++) begin
      vld_d[k]  = vld_q[k-1];
      tag_d[k]  = tag_q[k-1];
      pass_d[k] = pass_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) vld_q <= '0;
    else             vld_q <= vld_d;
  end

  // payload registers, clock-enabled by the incoming slot's valid
  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (vld_d[k]) begin
        tag_q[k]  <= tag_d[k];
        pass_q[k] <= pass_d[k];
        st_q[k]   <= st_d[k];
      end
    end
  end

  // unrolled rounds, each split after theta/rho/pi
  for (genvar i = 0; i < UNROLL; i++) begin : g_round
    kstate_t             rin;
    lane_t               rc;
    logic [ROUND_W-1:0]  ridx;

    if (i == 0) begin : g_head
      assign rin = head_state;
    end else begin : g_chain
      assign rin = st_q[2*i-1];
    end

    assign ridx = ROUND_W'(int'(pass_q[2*i]) * UNROLL + i);

    kp_theta_rho_pi u_trp (
      .a (rin),
      .b (st_d[2*i])
    );

    kp_rc_rom #(
      .NUM_ROUNDS (NUM_ROUNDS),
      .IDX_W      (ROUND_W)
    ) u_rc (
      .idx (ridx),
      .rc  (rc)
    );

    kp_chi_iota u_ci (
      .a  (st_q[2*i]),
      .rc (rc),
      .b  (st_d[2*i+1])
    );
  end

  assign out_valid = vld_q[LAST] && tail_final;
  assign out_tag   = tag_q[LAST];
  assign out_state = st_q[LAST];
endmodule

// File: rtl/kp1600_chk.sv
module kp1600_chk #(
  parameter int TAG_W  = 4,
  parameter int LAT    = 48,
  parameter int STAGES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             ready,
  input logic [TAG_W-1:0] tag,
  input logic             out_valid,
  input logic [TAG_W-1:0] out_tag
);
  localparam int CNT_W = $clog2(STAGES + 1) + 1;

  logic             acc;
  logic [LAT-1:0]   acc_sr;
  logic [TAG_W-1:0] tag_sr [LAT];
  logic [CNT_W-1:0] inflight;

  assign acc = start && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_sr   <= '0;
      inflight <= '0;
    end else begin
      acc_sr   <= {acc_sr[LAT-2:0], acc};
      inflight <= inflight + CNT_W'(acc) - CNT_W'(out_valid);
    end
  end

  always_ff @(posedge clk) begin
    tag_sr[0] <= tag;
    for (int k = 1; k < LAT; k++) tag_sr[k] <= tag_sr[k-1];
  end

  // R1
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight == '0) |-> (!out_valid && ready));
  // R3
  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == acc_sr[LAT-1]);
  // R4
  p_tag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_tag == tag_sr[LAT-1]));
  // R5
  p_capacity_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= CNT_W'(STAGES));
  // R6
  p_full_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight == CNT_W'(STAGES) && !out_valid) |-> !ready);
  // R7
  p_free_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ready);
endmodule

bind kp1600_pipe kp1600_chk #(
  .TAG_W  (TAG_W),
  .LAT    (2 * UNROLL * (NUM_ROUNDS / UNROLL)),
  .STAGES (2 * UNROLL)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .start     (in_start),
  .ready     (in_ready),
  .tag       (in_tag),
  .out_valid (out_valid),
  .out_tag   (out_tag)
);

// File: tb/kp1600_pipe_bench.sv
`timescale 1ns/1ps
module kp1600_pipe_bench;
  localparam int TAG_W = 4;
  localparam int LAT   = 48;

  logic              clk;
  logic              rst_n;
  logic              in_start;
  logic [TAG_W-1:0]  in_tag;
  logic [1599:0]     in_state;
  logic              in_ready;
  logic              out_valid;
  logic [TAG_W-1:0]  out_tag;
  logic [1599:0]     out_state;

  kp1600_pipe #(.TAG_W(TAG_W)) u_kp1600_pipe (
    .clk, .rst_n, .in_start, .in_tag, .in_state,
    .in_ready, .out_valid, .out_tag, .out_state
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // output monitor
  int               mon_n = 0;
  logic [TAG_W-1:0] mon_tag [32];
  logic [1599:0]    mon_st  [32];
  int               mon_cyc [32];
  always @(negedge clk) begin
    if (rst_n && out_valid && mon_n < 32) begin
      mon_tag[mon_n] = out_tag;
      mon_st[mon_n]  = out_state;
      mon_cyc[mon_n] = cyc;
      mon_n = mon_n + 1;
    end
  end

  // ---------------- reference model ----------------
  function automatic bit lfsr_bit(int t);
    logic [8:0] r;
    r = 9'h001;
    if (t % 255 == 0) return 1'b1;
    for (int i = 1; i <= t % 255; i++) begin
      r = {r[7:0], 1'b0};
      r[0] = r[0] ^ r[8];
      r[4] = r[4] ^ r[8];
      r[5] = r[5] ^ r[8];
      r[6] = r[6] ^ r[8];
      r[8] = 1'b0;
    end
    return r[0];
  endfunction

  function automatic logic [63:0] ref_rc(int ir);
    logic [63:0] v;
    v = '0;
    for (int j = 0; j < 7; j++) v[(1 << j) - 1] = lfsr_bit(j + 7 * ir);
    return v;
  endfunction

  function automatic logic [63:0] rl(logic [63:0] v, int n);
    if (n == 0) return v;
    return (v << n) | (v >> (64 - n));
  endfunction

  function automatic int rot_tab(int i);
    case (i)
      0: return 0;   1: return 1;   2: return 62;  3: return 28;  4: return 27;
      5: return 36;  6: return 44;  7: return 6;   8: return 55;  9: return 20;
      10: return 3;  11: return 10; 12: return 43; 13: return 25; 14: return 39;
      15: return 41; 16: return 45; 17: return 15; 18: return 21; 19: return 8;
      20: return 18; 21: return 2;  22: return 61; 23: return 56; 24: return 14;
      default: return 0;
    endcase
  endfunction

  function automatic logic [1599:0] ref_perm(logic [1599:0] s);
    logic [63:0] a [25];
    logic [63:0] bb [25];
    logic [63:0] c [5];
    logic [63:0] d [5];
    logic [1599:0] o;
    for (int i = 0; i < 25; i++) a[i] = s[64*i +: 64];
    for (int r = 0; r < 24; r++) begin
      for (int x = 0; x < 5; x++)
        c[x] = a[x] ^ a[x+5] ^ a[x+10] ^ a[x+15] ^ a[x+20];
      for (int x = 0; x < 5; x++)
        d[x] = c[(x+4)%5] ^ rl(c[(x+1)%5], 1);
      for (int y = 0; y < 5; y++)
        for (int x = 0; x < 5; x++)
          a[x+5*y] = a[x+5*y] ^ d[x];
      for (int y = 0; y < 5; y++)
        for (int x = 0; x < 5; x++)
          bb[y + 5*((2*x+3*y)%5)] = rl(a[x+5*y], rot_tab(x+5*y));
      for (int y = 0; y < 5; y++)
        for (int x = 0; x < 5; x++)
          a[x+5*y] = bb[x+5*y] ^ (~bb[(x+1)%5+5*y] & bb[(x+2)%5+5*y]);
      a[0] = a[0] ^ ref_rc(r);
    end
    for (int i = 0; i < 25; i++) o[64*i +: 64] = a[i];
    return o;
  endfunction

  function automatic logic [1599:0] mk_state(logic [63:0] seed);
    logic [1599:0] s;
    logic [63:0]   v;
    v = seed;
    for (int i = 0; i < 25; i++) begin
      v = v ^ (v << 13);
      v = v ^ (v >> 7);
      v = v ^ (v << 17);
      s[64*i +: 64] = v;
    end
    return s;
  endfunction

  // ---------------- check helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req, input string what,
                             input logic [1599:0] act, input logic [1599:0] exp);
    int bad;
    bad = -1;
    for (int i = 24; i >= 0; i--) if (act[64*i +: 64] !== exp[64*i +: 64]) bad = i;
    n_chk++;
    if (bad >= 0) begin
      n_err++;
      $display("FAIL %s %s lane %0d actual=%h expected=%h", req, what, bad,
               act[64*bad +: 64], exp[64*bad +: 64]);
    end
  endtask

  task automatic wait_outputs(input int target, input int limit);
    for (int i = 0; i < limit; i++) begin
      if (mon_n >= target) break;
      @(negedge clk); #1;
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst_n = 1'b0; in_start = 1'b0; in_tag = '0; in_state = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R1", "ready after reset", 64'(in_ready), 64'd1);
    check(out_valid == 1'b0, "R1", "valid after reset", 64'(out_valid), 64'd0);
    repeat (5) @(negedge clk);
    check(out_valid == 1'b0, "R1", "valid idle", 64'(out_valid), 64'd0);
  endtask

  task automatic t_single(input logic [1599:0] s, input logic [TAG_W-1:0] tg,
                          input bit zero_kat);
    int base;
    int c0;
    logic [1599:0] exp;
    base = mon_n;
    exp = ref_perm(s);
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "ready before single", 64'(in_ready), 64'd1);
    c0 = cyc;
    in_start = 1'b1; in_tag = tg; in_state = s;
    @(negedge clk);
    in_start = 1'b0; in_state = '0;
    wait_outputs(base + 1, 120);
    check(mon_n == base + 1, "R3", "single result count", 64'(mon_n - base), 64'd1);
    if (mon_n > base) begin
      check(mon_cyc[base] == c0 + LAT, "R3", "single latency",
            64'(mon_cyc[base] - c0), 64'(LAT));
      check(mon_tag[base] == tg, "R4", "single tag", 64'(mon_tag[base]), 64'(tg));
      check_state("R2", "single state", mon_st[base], exp);
      if (zero_kat)
        check(mon_st[base][63:0] == 64'hF1258F7940E1DDE7, "R8", "zero-state lane0 constant",
              mon_st[base][63:0], 64'hF1258F7940E1DDE7);
    end
    @(negedge clk);
    check(out_valid == 1'b0, "R3", "valid is a single pulse", 64'(out_valid), 64'd0);
  endtask

  task automatic t_burst();
    int base;
    int c0;
    logic [1599:0] s [4];
    for (int k = 0; k < 4; k++) s[k] = mk_state(64'h1234_5678_9ABC_DEF0 + 64'(k) * 64'h77);
    base = mon_n;
    @(negedge clk);
    c0 = cyc;
    for (int k = 0; k < 4; k++) begin
      check(in_ready == 1'b1, "R5", "ready during fill", 64'(in_ready), 64'd1);
      in_start = 1'b1; in_tag = TAG_W'(k + 1); in_state = s[k];
      @(negedge clk);
    end
    in_start = 1'b0;
    check(in_ready == 1'b0, "R6", "ready low when loop full", 64'(in_ready), 64'd0);
    repeat (6) @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      check(in_ready == 1'b0, "R6", "ready low while blocked", 64'(in_ready), 64'd0);
      in_start = 1'b1; in_tag = TAG_W'(9); in_state = mk_state(64'hDEAD);
      @(negedge clk);
    end
    in_start = 1'b0;
    while (cyc < c0 + LAT + 12) @(negedge clk);
    #1;
    check(mon_n == base + 4, "R6", "blocked starts yield no result", 64'(mon_n - base), 64'd4);
    for (int k = 0; k < 4; k++) begin
      if (mon_n > base + k) begin
        check(mon_tag[base+k] == TAG_W'(k + 1), "R5", "burst order/tag",
              64'(mon_tag[base+k]), 64'(k + 1));
        check(mon_cyc[base+k] == c0 + LAT + k, "R5", "burst back-to-back timing",
              64'(mon_cyc[base+k] - c0), 64'(LAT + k));
        check_state("R9", "interleaved state", mon_st[base+k], ref_perm(s[k]));
      end
    end
  endtask

  task automatic t_overlap();
    int base;
    int c0;
    int ca;
    logic [1599:0] s [5];
    for (int k = 0; k < 5; k++) s[k] = mk_state(64'h0F0F_3C3C_5A5A_9696 ^ 64'(k * 31 + 5));
    base = mon_n;
    ca = -1;
    @(negedge clk);
    c0 = cyc;
    for (int k = 0; k < 4; k++) begin
      in_start = 1'b1; in_tag = TAG_W'(k + 11); in_state = s[k];
      @(negedge clk);
    end
    in_tag = TAG_W'(10); in_state = s[4];
    for (int i = 0; i < 100; i++) begin
      if (in_ready) begin
        ca = cyc;
        check(out_valid == 1'b1, "R7", "accept coincides with completion",
              64'(out_valid), 64'd1);
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    in_start = 1'b0;
    check(ca == c0 + LAT, "R7", "pending start accepted at first completion",
          64'(ca - c0), 64'(LAT));
    wait_outputs(base + 5, 120);
    check(mon_n == base + 5, "R7", "overlap result count", 64'(mon_n - base), 64'd5);
    if (mon_n >= base + 5) begin
      check(mon_tag[base+4] == TAG_W'(10), "R4", "late tag", 64'(mon_tag[base+4]), 64'd10);
      check(mon_cyc[base+4] == ca + LAT, "R3", "late latency",
            64'(mon_cyc[base+4] - ca), 64'(LAT));
      check_state("R2", "late state", mon_st[base+4], ref_perm(s[4]));
      check_state("R9", "first of overlap burst", mon_st[base], ref_perm(s[0]));
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single('0, TAG_W'(5), 1'b1);
    t_single(mk_state(64'hA5A5_0123_4567_89AB), TAG_W'(3), 1'b0);
    t_burst();
    t_overlap();
    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule